// File: doc/BRIEF.md
# Series-Cell Protection Controller

This block is the digital decision core of a protector for a pack of three or four lithium cells in series. Analog comparators outside the block report, for every cell, whether it is above the over-charge trip, below the over-charge release level, below the over-discharge trip, and above the over-discharge release level. A further flag reports that a charger has been detected. The block turns these flags into three things:

- a charge-switch block;
- a discharge-switch block;
- one bleed enable per cell, which turns on a balancing current source for a cell that has been overcharged.

Qualification delays are counted on a slow `tick` strobe. Each delay's length in ticks comes from a configuration input. The length scales linearly with that value: one unit stands in for one step of timing capacitance, about 11.8 ms per unit, with roughly 21 ms at the smallest setting.

The controller also owns the power state. It leaves reset asleep and wakes only when the charger flag is seen. A qualified over-discharge puts it back to sleep. While asleep, only cells that are already overcharged stay watched: their bleed stays on until they fall to the release level. Every control pin is a plain level signal. No pin of the block carries a data stream, so no pin has a valid/ready handshake.

Top module: `cellguard_ctrl`

## Requirements
- R1: While awake, a cell that holds its over-charge flag through N consecutive ticks (N = `oc_delay`, a value of 0 counts as 1) enters the overcharged state. `chg_block` then rises and stays high while any cell is overcharged.
- R2: An overcharged cell leaves that state as soon as its below-release flag is seen, with no tick needed.
- R3: A cell that holds its over-discharge flag through N consecutive ticks while awake (N = `od_delay`, 0 counts as 1) becomes over-discharged. `dsg_block` rises and the block enters sleep (`sleep_mode` = 1).
- R4: While awake, an over-discharged cell clears as soon as its above-release flag is seen, and `dsg_block` falls when no cell is over-discharged.
- R5: `bleed_en[i]` is 1 exactly while cell i is overcharged. Bleed enables of other cells stay 0.
- R6: With `full_count` = 0 the top cell (index CELLS-1) is inactive: its flags have no effect and its bleed enable stays 0. With `full_count` = 1 all cells take part.
- R7: After reset, `sleep_mode` = 1 and `dsg_block` = 1. A seen charger flag wakes the block (`sleep_mode` = 0). The charger flag has no effect while awake.
- R8: While asleep, no over-discharge or over-charge state is set and no over-discharge state clears. An already overcharged cell keeps its bleed and still clears on its release flag.
- R9: A qualification count restarts from zero whenever its flag drops before the delay expires, so an excursion shorter than N ticks never trips.
- R10: `chg_block` and `dsg_block` may be high together, and each falls on its own release without affecting the other.
- R11: Every flag passes through a two-flop synchronizer and every output is registered. A release flag applied before a clock edge shows at the outputs after the fourth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One-cycle strobe that advances qualification counts |
| full_count | input | 1 | 1 = all CELLS cells active, 0 = top cell dropped |
| oc_above | input | CELLS | Cell is above the over-charge trip |
| oc_below_rel | input | CELLS | Cell is below the over-charge release level |
| od_below | input | CELLS | Cell is below the over-discharge trip |
| od_above_rel | input | CELLS | Cell is above the over-discharge release level |
| chg_seen | input | 1 | Charger detected (sense pin above supply) |
| oc_delay | input | DLY_W | Over-charge qualification length in ticks |
| od_delay | input | DLY_W | Over-discharge qualification length in ticks |
| chg_block | output | 1 | Turn the charge switch off |
| dsg_block | output | 1 | Turn the discharge switch off |
| bleed_en | output | CELLS | Per-cell balancing bleed enable |
| sleep_mode | output | 1 | 1 while in power-down |

## Verification
The assertions take the comparator flags as physically consistent:

- A cell never reports above-trip and below-release at once.
- It never reports below-trip and above-release at once.
- `tick` is one clock wide.
- The delay inputs change only while no count is running, which the counter-bound property relies on.
- `full_count` holds steady around any window it is checked in.

The stimulus keeps within these rules by driving each cell only to one of four legal levels: normal, overcharged, inside a hysteresis band, or discharged. It changes delays and cell count only when every cell sits at the normal level.

// File: rtl/cg_pkg.sv
package cg_pkg;

  typedef enum logic {
    PM_RUN   = 1'b0,
    PM_SLEEP = 1'b1
  } pmode_e;

  typedef struct packed {
    logic oc_hi;
    logic oc_rel;
    logic od_lo;
    logic od_rel;
  } cell_flags_t;

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] s1;
  logic [W-1:0] s2;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[b] <= 1'b0;
        s2[b] <= 1'b0;
      end else begin
        s1[b] <= d[b];
        s2[b] <= s1[b];
      end
    end
  end

  assign q = s2;

endmodule

// File: rtl/cg_delay_timer.sv
module cg_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expire
);

  localparam logic [W:0] ONE = (W+1)'(1);

  logic [W-1:0] cnt;
  logic [W:0]   nxt;
  logic [W:0]   lim_eff;

  always_comb begin
    lim_eff = (limit == '0) ? ONE : {1'b0, limit};
    nxt     = {1'b0, cnt} + ONE;
    expire  = run & tick & (nxt >= lim_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= expire ? '0 : nxt[W-1:0];
    end
  end

  // R9: a running count never reaches the effective limit
  p_cnt_below_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, cnt} < lim_eff));

  // R9: a dropped condition leaves the count at zero
  p_cnt_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

endmodule

// File: rtl/cg_cell.sv
module cg_cell
  import cg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        active,
  input  logic        sleep,
  input  cell_flags_t flg,
  input  logic [W-1:0] oc_limit,
  input  logic [W-1:0] od_limit,
  output logic        ovc,
  output logic        ovd,
  output logic        ovd_trip
);

  logic oc_run;
  logic od_run;
  logic oc_exp;
  logic od_exp;

  assign oc_run = active & flg.oc_hi & ~ovc & ~sleep;
  assign od_run = active & flg.od_lo & ~ovd & ~sleep;

  cg_delay_timer #(.W(W)) u_oc_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .run    (oc_run),
    .limit  (oc_limit),
    .expire (oc_exp)
  );

  cg_delay_timer #(.W(W)) u_od_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .run    (od_run),
    .limit  (od_limit),
    .expire (od_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovc <= 1'b0;
      ovd <= 1'b0;
    end else if (!active) begin
      ovc <= 1'b0;
      ovd <= 1'b0;
    end else begin
      if (ovc && flg.oc_rel)
        ovc <= 1'b0;
      else if (oc_exp)
        ovc <= 1'b1;

      if (ovd && !sleep && flg.od_rel)
        ovd <= 1'b0;
      else if (od_exp)
        ovd <= 1'b1;
    end
  end

  assign ovd_trip = od_exp;

  // R6: an inactive cell holds no protection state
  p_inactive_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!ovc && !ovd));

  // R8: sleep freezes the over-discharge state
  p_sleep_hold_od_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && active && ovd) |=> ovd);

  // R8: no new overcharge qualifies while asleep
  p_sleep_no_new_oc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !ovc) |=> !ovc);

endmodule

// File: rtl/cellguard_ctrl.sv
module cellguard_ctrl
  import cg_pkg::*;
#(
  parameter int CELLS = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             full_count,
  input  logic [CELLS-1:0] oc_above,
  input  logic [CELLS-1:0] oc_below_rel,
  input  logic [CELLS-1:0] od_below,
  input  logic [CELLS-1:0] od_above_rel,
  input  logic             chg_seen,
  input  logic [DLY_W-1:0] oc_delay,
  input  logic [DLY_W-1:0] od_delay,
  output logic             chg_block,
  output logic             dsg_block,
  output logic [CELLS-1:0] bleed_en,
  output logic             sleep_mode
);

  localparam int FLAG_W = 4*CELLS + 1;

  logic [FLAG_W-1:0] raw;
  logic [FLAG_W-1:0] synced;
  logic              chg_s;
  cell_flags_t       flg [CELLS];
  logic [CELLS-1:0]  active;
  logic [CELLS-1:0]  ovc;
  logic [CELLS-1:0]  ovd;
  logic [CELLS-1:0]  trip;
  pmode_e            pm;
  logic              sleep;

  assign raw = {chg_seen, od_above_rel, od_below, oc_below_rel, oc_above};

  cg_sync #(.W(FLAG_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (synced)
  );

  assign chg_s = synced[FLAG_W-1];
  assign sleep = (pm == PM_SLEEP);

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign flg[i] = {synced[i], synced[CELLS+i], synced[2*CELLS+i], synced[3*CELLS+i]};

    if (i == CELLS-1) begin : g_top
      assign active[i] = full_count;
    end else begin : g_low
      assign active[i] = 1'b1;
    end

    cg_cell #(.W(DLY_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .active   (active[i]),
      .sleep    (sleep),
      .flg      (flg[i]),
      .oc_limit (oc_delay),
      .od_limit (od_delay),
      .ovc      (ovc[i]),
      .ovd      (ovd[i]),
      .ovd_trip (trip[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm <= PM_SLEEP;
    end else begin
      case (pm)
        PM_SLEEP: if (chg_s) pm <= PM_RUN;
        PM_RUN:   if (|trip) pm <= PM_SLEEP;
        default:  pm <= PM_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_block <= 1'b0;
      dsg_block <= 1'b1;
      bleed_en  <= '0;
    end else begin
      chg_block <= |ovc;
      dsg_block <= sleep | (|ovd);
      bleed_en  <= ovc;
    end
  end

  assign sleep_mode = sleep;

  // R1: the charge block only rises as a result of a tick
  p_chg_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_block) |-> $past(tick, 2));

  // R3: the discharge block only rises as a result of a tick
  p_dsg_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsg_block) |-> $past(tick, 2));

  // R3: entering sleep always blocks discharge
  p_sleep_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_mode) |=> dsg_block);

  // R7: waking needs the charger flag three edges earlier
  p_wake_by_charger_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_mode) |-> $past(chg_seen, 3));

  // R6: the dropped top cell never bleeds
  p_idle_cell_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_count && $past(!full_count) && $past(!full_count, 2)) |-> !bleed_en[CELLS-1]);

endmodule

// File: tb/sim_cellguard_ctrl.sv
module sim_cellguard_ctrl;

  localparam int CELLS = 4;
  localparam int DLY_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             full_count = 1'b1;
  logic [CELLS-1:0] oc_above = '0;
  logic [CELLS-1:0] oc_below_rel = '1;
  logic [CELLS-1:0] od_below = '0;
  logic [CELLS-1:0] od_above_rel = '1;
  logic             chg_seen = 1'b0;
  logic [DLY_W-1:0] oc_delay = 8'd1;
  logic [DLY_W-1:0] od_delay = 8'd1;
  logic             chg_block;
  logic             dsg_block;
  logic [CELLS-1:0] bleed_en;
  logic             sleep_mode;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cellguard_ctrl #(.CELLS(CELLS), .DLY_W(DLY_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .full_count(full_count),
    .oc_above(oc_above), .oc_below_rel(oc_below_rel),
    .od_below(od_below), .od_above_rel(od_above_rel),
    .chg_seen(chg_seen), .oc_delay(oc_delay), .od_delay(od_delay),
    .chg_block(chg_block), .dsg_block(dsg_block),
    .bleed_en(bleed_en), .sleep_mode(sleep_mode)
  );

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic one_tick;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    clks(3);
  endtask

  // cell levels: normal, overcharged, in-band, discharged
  task automatic set_normal(input int c);
    oc_above[c] = 1'b0; oc_below_rel[c] = 1'b1;
    od_below[c] = 1'b0; od_above_rel[c] = 1'b1;
  endtask

  task automatic set_over(input int c);
    oc_above[c] = 1'b1; oc_below_rel[c] = 1'b0;
  endtask

  task automatic set_low(input int c);
    od_below[c] = 1'b1; od_above_rel[c] = 1'b0;
  endtask

  task automatic wake;
    chg_seen = 1'b1;
    clks(6);
    chg_seen = 1'b0;
    clks(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clks(5);
    rst_n = 1'b1;
    clks(2);
    // R7 reset state
    chg_block_chk: begin
      chk("R7 reset sleep", 32'(sleep_mode), 1);
      chk("R7 reset dsg", 32'(dsg_block), 1);
      chk("R1 reset chg", 32'(chg_block), 0);
      chk("R5 reset bleed", 32'(bleed_en), 0);
    end
    // R8: overcharge cannot qualify while asleep
    set_over(0);
    clks(4);
    repeat (4) one_tick();
    chk("R8 no oc in sleep", 32'(chg_block), 0);
    set_normal(0);
    clks(4);
    wake();
    chk("R7 woken", 32'(sleep_mode), 0);
    chk("R7 dsg off after wake", 32'(dsg_block), 0);

    // sweep: cell count, cell, delay value
    for (int m = 0; m < 2; m++) begin
      full_count = m[0];
      clks(4);
      for (int c = 0; c < (m == 1 ? CELLS : CELLS-1); c++) begin
        for (int d = 0; d < 6; d++) begin
          int eff;
          eff = (d == 0) ? 1 : d;
          oc_delay = 8'(d);
          od_delay = 8'(d);
          clks(2);
          // R1 / R5 over-charge qualification
          set_over(c);
          clks(4);
          for (int t = 0; t < eff-1; t++) begin
            one_tick();
            chk("R1 not yet tripped", 32'(chg_block), 0);
          end
          one_tick();
          chk("R1 tripped", 32'(chg_block), 1);
          chk("R5 own bleed only", 32'(bleed_en), 32'(1 << c));
          // R2 / R11 immediate release, four-edge latency
          oc_above[c] = 1'b0;
          oc_below_rel[c] = 1'b1;
          clks(3);
          chk("R11 still held after three edges", 32'(chg_block), 1);
          clks(1);
          chk("R2 released without tick", 32'(chg_block), 0);
          chk("R5 bleed released", 32'(bleed_en), 0);
          // R3 over-discharge qualification
          set_low(c);
          clks(4);
          for (int t = 0; t < eff-1; t++) begin
            one_tick();
            chk("R3 not yet tripped", 32'(dsg_block), 0);
          end
          one_tick();
          chk("R3 dsg tripped", 32'(dsg_block), 1);
          chk("R3 sleep entered", 32'(sleep_mode), 1);
          set_normal(c);
          clks(8);
          chk("R8 od held in sleep", 32'(dsg_block), 1);
          wake();
          chk("R7 woken by charger", 32'(sleep_mode), 0);
          chk("R4 dsg released", 32'(dsg_block), 0);
        end
      end
    end

    // R6: top cell ignored in reduced mode
    full_count = 1'b0;
    oc_delay = 8'd1;
    od_delay = 8'd1;
    clks(4);
    set_over(CELLS-1);
    set_low(CELLS-1);
    clks(4);
    repeat (6) one_tick();
    chk("R6 top chg ignored", 32'(chg_block), 0);
    chk("R6 top dsg ignored", 32'(dsg_block), 0);
    chk("R6 top bleed off", 32'(bleed_en), 0);
    set_normal(CELLS-1);
    clks(4);
    full_count = 1'b1;
    clks(4);

    // R9: short excursion restarts the count
    oc_delay = 8'd4;
    clks(2);
    set_over(2);
    clks(4);
    repeat (3) one_tick();
    oc_above[2] = 1'b0;
    clks(4);
    one_tick();
    oc_above[2] = 1'b1;
    clks(4);
    repeat (3) one_tick();
    chk("R9 no trip after restart", 32'(chg_block), 0);
    one_tick();
    chk("R9 trip after full run", 32'(chg_block), 1);
    set_normal(2);
    clks(5);
    chk("R2 released", 32'(chg_block), 0);

    // R7: charger flag ignored while awake
    wake();
    chk("R7 charger in run", 32'(sleep_mode), 0);
    chk("R7 charger in run dsg", 32'(dsg_block), 0);

    // R4: release while awake, cell held in band through wake
    od_delay = 8'd2;
    clks(2);
    set_low(1);
    clks(4);
    repeat (2) one_tick();
    od_below[1] = 1'b0;
    clks(4);
    wake();
    chk("R4 awake with od held", 32'(dsg_block), 1);
    chk("R4 awake state", 32'(sleep_mode), 0);
    od_above_rel[1] = 1'b1;
    clks(5);
    chk("R4 awake release", 32'(dsg_block), 0);

    // R8 / R10: overcharged cell survives sleep, blocks release apart
    oc_delay = 8'd2;
    clks(2);
    set_over(1);
    clks(4);
    repeat (2) one_tick();
    set_low(2);
    clks(4);
    repeat (2) one_tick();
    chk("R10 both blocks", 32'({chg_block, dsg_block}), 32'h3);
    chk("R8 asleep", 32'(sleep_mode), 1);
    set_normal(2);
    set_over(0);
    clks(4);
    repeat (5) one_tick();
    chk("R8 bleed kept, no new oc", 32'(bleed_en), 32'h2);
    set_normal(0);
    oc_above[1] = 1'b0;
    oc_below_rel[1] = 1'b1;
    clks(5);
    chk("R8 release in sleep", 32'(bleed_en), 0);
    chk("R10 chg released alone", 32'({chg_block, dsg_block}), 32'h1);
    wake();
    chk("R10 dsg released", 32'(dsg_block), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule